// File: doc/BRIEF.md
# Dual-Stack Threaded-Code Processor Core

A compact 16-bit stack processor for threaded code. Every instruction word is either a subroutine call, which carries no opcode, or a bundle of three 5-bit opcodes that run in sequence. Both stacks live in main memory. One holds return addresses and the other holds data. Each stack is addressed by a pointer register that steps up on a push and down on a pop, and wraps inside a power-of-two region, so each stack behaves as a circular buffer.

Subtract is the only arithmetic operation, and it sets a borrow flag. There is no conditional-branch opcode. A skip opcode adds one to the saved return address when borrow is set, so the following return skips one word of the caller. The core talks to a synchronous single-port 16-bit memory with one cycle of read latency. The registers are the program counter, the instruction word, the two stack pointers and one operand latch, plus the borrow flag.

Top module: `tcc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core drives a read of address 0 and no write. Reset sets the PC to 0, places both stack pointers at their region bases and clears borrow.
- R2: A word with bit 15 = 0 is a call. It writes PC+1 (the address after the call word) to the return stack and then fetches from the word address in bits 14:0.
- R3: A word with bit 15 = 1 holds three opcodes, in bits 14:10, 9:5 and 4:0. They execute in that order.
- R4: A push writes to the address held in the stack pointer and then increments the pointer. A pop first decrements the pointer and then reads from the new address.
- R5: A pointer update changes only the low DEPTH_W bits of the pointer, so it wraps modulo the region size. The upper bits stay equal to the region base.
- R6: Opcode 3 (subtract) pops the top item b, then pops the next item a, and pushes a-b mod 2^16. Borrow is set exactly when a < b, with both values treated as unsigned.
- R7: Opcode 1 (return) pops the return stack into the PC. Any opcodes that remain in the same word are discarded.
- R8: Opcode 2 (skip) does nothing when borrow is clear. When borrow is set, it adds 1 to the top entry of the return stack by popping it and pushing it back, so the pointer ends where it started.
- R9: Opcode 4 (literal) pushes the word that follows in the instruction stream, and the PC steps past that word. Opcode 5 duplicates the top data item. Opcode 6 drops the top data item with no memory access. Opcode 7 moves an item from the data stack to the return stack, and opcode 8 moves one from the return stack to the data stack. Opcode 0 and opcodes 9 to 31 do nothing.
- R10: Read data is taken in the cycle after mem_re_o is asserted. In any cycle the core asserts at most one of mem_re_o and mem_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | DW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid one cycle after a read |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |

## Verification
The hardest state to reach from the ports is a skip taken on borrow, because it changes a return address that the core itself saved. Reaching it takes a subtraction that borrows, then a call, then the skip followed by a return. The effect can be seen only in which caller word runs next. The stimulus consists of small programs loaded into a memory model. In each program, the path taken is revealed by a distinct literal that gets pushed, and a second program runs the same path without a borrow. Pointer wrap is reached in two ways: by pushing one item more than the data region holds, and by popping from the empty stack right after reset.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int OP_W  = 5;
  localparam int SLOTS = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 5'd0,
    OP_RET   = 5'd1,
    OP_SKB   = 5'd2,
    OP_SUB   = 5'd3,
    OP_LIT   = 5'd4,
    OP_DUP   = 5'd5,
    OP_DROP  = 5'd6,
    OP_TOR   = 5'd7,
    OP_FROMR = 5'd8
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2
  } state_e;
endpackage

// File: rtl/tcc_stkptr.sv
module tcc_stkptr #(
  parameter int           W       = 16,
  parameter int           DEPTH_W = 4,
  parameter logic [W-1:0] BASE    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ptr_dec_o
);
  localparam logic [DEPTH_W-1:0] STEP = 1;
  localparam logic [W-DEPTH_W-1:0] HI = BASE[W-1:DEPTH_W];

  logic [DEPTH_W-1:0] low_q;
  logic [DEPTH_W-1:0] low_dec;

  assign low_dec   = low_q - STEP;
  assign ptr_o     = {HI, low_q};
  assign ptr_dec_o = {HI, low_dec};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_q <= BASE[DEPTH_W-1:0];
    else if (inc_i) low_q <= low_q + STEP;
    else if (dec_i) low_q <= low_dec;
  end

  p_region_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[W-1:DEPTH_W] == HI);
  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && dec_i));
  p_dec_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && low_q == '0) |=> (low_q == '1));
endmodule

// File: rtl/tcc_slot_dec.sv
module tcc_slot_dec
  import tcc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SLOT_W = 2
) (
  input  logic [DW-1:0]     ir_i,
  input  logic [SLOT_W-1:0] slot_i,
  output op_e               op_o,
  output logic              last_o
);
  logic [OP_W-1:0] fld [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_fld
    assign fld[k] = ir_i[(SLOTS-1-k)*OP_W +: OP_W];
  end

  assign op_o   = op_e'(fld[slot_i]);
  assign last_o = (slot_i == SLOT_W'(SLOTS-1));
endmodule

// File: rtl/tcc_sub_unit.sv
module tcc_sub_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o
);
  assign {borrow_o, diff_o} = {1'b0, a_i} - {1'b0, b_i};
endmodule

// File: rtl/tcc_core.sv
module tcc_core
  import tcc_pkg::*;
#(
  parameter int            DW         = 16,
  parameter logic [DW-1:0] RS_BASE    = 16'hF000,
  parameter int            RS_DEPTH_W = 4,
  parameter logic [DW-1:0] DS_BASE    = 16'hE000,
  parameter int            DS_DEPTH_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic          mem_re_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [DW-1:0] ONE = 1;

  state_e state_q, state_d;
  logic [DW-1:0] pc_q, pc_d, ir_q, ir_d, tmp_q, tmp_d;
  logic borrow_q, borrow_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [1:0] stp_q, stp_d;
  logic rs_inc, rs_dec, ds_inc, ds_dec;
  logic [DW-1:0] rp, rp_dec, dp, dp_dec;
  op_e op;
  logic last_slot;
  logic [DW-1:0] diff;
  logic bout;

  tcc_stkptr #(.W(DW), .DEPTH_W(RS_DEPTH_W), .BASE(RS_BASE)) i_rs_ptr (
    .clk_i, .rst_ni, .inc_i(rs_inc), .dec_i(rs_dec), .ptr_o(rp), .ptr_dec_o(rp_dec));
  tcc_stkptr #(.W(DW), .DEPTH_W(DS_DEPTH_W), .BASE(DS_BASE)) i_ds_ptr (
    .clk_i, .rst_ni, .inc_i(ds_inc), .dec_i(ds_dec), .ptr_o(dp), .ptr_dec_o(dp_dec));
  tcc_slot_dec #(.DW(DW), .SLOT_W(SLOT_W)) i_slot_dec (
    .ir_i(ir_q), .slot_i(slot_q), .op_o(op), .last_o(last_slot));
  tcc_sub_unit #(.W(DW)) i_sub (
    .a_i(mem_rdata_i), .b_i(tmp_q), .diff_o(diff), .borrow_o(bout));

  always_comb begin
    state_d = state_q; pc_d = pc_q; ir_d = ir_q; tmp_d = tmp_q;
    borrow_d = borrow_q; slot_d = slot_q; stp_d = stp_q;
    rs_inc = 1'b0; rs_dec = 1'b0; ds_inc = 1'b0; ds_dec = 1'b0;
    mem_addr_o = pc_q; mem_wdata_o = '0; mem_we_o = 1'b0; mem_re_o = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_re_o = 1'b1;
        pc_d     = pc_q + ONE;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        if (!mem_rdata_i[DW-1]) begin  // call: no opcode
          mem_addr_o = rp; mem_wdata_o = pc_q; mem_we_o = 1'b1; rs_inc = 1'b1;
          pc_d    = {1'b0, mem_rdata_i[DW-2:0]};
          state_d = ST_FETCH;
        end else begin
          ir_d = mem_rdata_i; slot_d = '0; stp_d = '0;
          state_d = ST_EXEC;
        end
      end
      default: begin
        logic adv;
        adv = 1'b0;
        case (op)
          OP_RET: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = rp_dec; mem_re_o = 1'b1; rs_dec = 1'b1; stp_d = 2'd1;
            end else begin
              pc_d = mem_rdata_i; stp_d = '0; state_d = ST_FETCH;
            end
          end
          OP_SKB: begin
            if (!borrow_q) adv = 1'b1;
            else if (stp_q == 2'd0) begin
              mem_addr_o = rp_dec; mem_re_o = 1'b1; rs_dec = 1'b1; stp_d = 2'd1;
            end else begin
              mem_addr_o = rp; mem_wdata_o = mem_rdata_i + ONE; mem_we_o = 1'b1;
              rs_inc = 1'b1; adv = 1'b1;
            end
          end
          OP_SUB: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = dp_dec; mem_re_o = 1'b1; ds_dec = 1'b1; stp_d = 2'd1;
            end else if (stp_q == 2'd1) begin
              tmp_d = mem_rdata_i;
              mem_addr_o = dp_dec; mem_re_o = 1'b1; ds_dec = 1'b1; stp_d = 2'd2;
            end else begin
              mem_addr_o = dp; mem_wdata_o = diff; mem_we_o = 1'b1; ds_inc = 1'b1;
              borrow_d = bout; adv = 1'b1;
            end
          end
          OP_LIT: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = pc_q; mem_re_o = 1'b1; pc_d = pc_q + ONE; stp_d = 2'd1;
            end else begin
              mem_addr_o = dp; mem_wdata_o = mem_rdata_i; mem_we_o = 1'b1;
              ds_inc = 1'b1; adv = 1'b1;
            end
          end
          OP_DUP: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = dp_dec; mem_re_o = 1'b1; ds_dec = 1'b1; stp_d = 2'd1;
            end else if (stp_q == 2'd1) begin
              mem_addr_o = dp; mem_wdata_o = mem_rdata_i; mem_we_o = 1'b1;
              ds_inc = 1'b1; tmp_d = mem_rdata_i; stp_d = 2'd2;
            end else begin
              mem_addr_o = dp; mem_wdata_o = tmp_q; mem_we_o = 1'b1;
              ds_inc = 1'b1; adv = 1'b1;
            end
          end
          OP_DROP: begin
            ds_dec = 1'b1; adv = 1'b1;
          end
          OP_TOR: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = dp_dec; mem_re_o = 1'b1; ds_dec = 1'b1; stp_d = 2'd1;
            end else begin
              mem_addr_o = rp; mem_wdata_o = mem_rdata_i; mem_we_o = 1'b1;
              rs_inc = 1'b1; adv = 1'b1;
            end
          end
          OP_FROMR: begin
            if (stp_q == 2'd0) begin
              mem_addr_o = rp_dec; mem_re_o = 1'b1; rs_dec = 1'b1; stp_d = 2'd1;
            end else begin
              mem_addr_o = dp; mem_wdata_o = mem_rdata_i; mem_we_o = 1'b1;
              ds_inc = 1'b1; adv = 1'b1;
            end
          end
          default: adv = 1'b1;
        endcase
        if (adv) begin
          stp_d = '0;
          if (last_slot) state_d = ST_FETCH;
          else           slot_d  = slot_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH; pc_q <= '0; ir_q <= '0; tmp_q <= '0;
      borrow_q <= 1'b0; slot_q <= '0; stp_q <= '0;
    end else begin
      state_q <= state_d; pc_q <= pc_d; ir_q <= ir_d; tmp_q <= tmp_d;
      borrow_q <= borrow_d; slot_q <= slot_d; stp_q <= stp_d;
    end
  end

  p_one_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_call_jump_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && !mem_rdata_i[DW-1]) |=>
      (state_q == ST_FETCH && pc_q == {1'b0, $past(mem_rdata_i[DW-2:0])}));
  p_ret_pc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_RET && stp_q == 2'd1) |=>
      (state_q == ST_FETCH && pc_q == $past(mem_rdata_i)));
  p_borrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_SUB && stp_q == 2'd2) |=>
      (borrow_q == ($past(mem_rdata_i) < $past(tmp_q))));
  p_skb_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_SKB && !borrow_q) |-> (!mem_re_o && !mem_we_o));
endmodule

// File: tb/test_tcc_core.sv
module test_tcc_core;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, mem_re;
  int n_checks = 0;
  int n_fail = 0;
  bit active = 1'b0;

  localparam int NOP = 0, RET = 1, SKB = 2, SUB = 3, LIT = 4, DUP = 5,
                 DROP = 6, TOR = 7, FROMR = 8;

  always #10 clk = ~clk;

  tcc_core #(.DW(16), .RS_BASE(16'h0300), .RS_DEPTH_W(4),
             .DS_BASE(16'h0200), .DS_DEPTH_W(3)) i_tcc_core (
    .clk_i(clk), .rst_ni, .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_re_o(mem_re));

  logic [15:0] ram [1024];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[9:0]];
  end

  logic [31:0] q_exp [$];
  string       q_tag [$];

  function automatic logic [15:0] wd(int a, int b, int c);
    return {1'b1, a[4:0], b[4:0], c[4:0]};
  endfunction
  function automatic logic [15:0] cw(int t);
    return {1'b0, t[14:0]};
  endfunction

  task automatic expect_wr(logic [15:0] a, logic [15:0] d, string tag);
    q_exp.push_back({a, d});
    q_tag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compare each write against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && active && mem_we && q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({mem_addr, mem_wdata} == e, t, {mem_addr, mem_wdata}, e);
      check(!mem_re, "R10 single access", {31'b0, mem_re}, 32'h0);
    end
  end

  task automatic load_begin();
    active = 1'b0;
    rst_ni = 1'b0;
    for (int i = 0; i < 1024; i++) ram[i] = 16'h0;
    q_exp.delete();
    q_tag.delete();
  endtask

  task automatic run(string name);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!mem_we, "R1 no write in reset", {31'b0, mem_we}, 32'h0);
    rst_ni = 1'b1;
    active = 1'b1;
    #1;
    check(mem_re && !mem_we && mem_addr == 16'h0, "R1 first fetch at 0",
          {mem_re, mem_we, 14'b0, mem_addr}, {1'b1, 1'b0, 30'h0});
    for (int c = 0; c < 2000 && q_exp.size() > 0; c++) @(posedge clk);
    @(negedge clk);
    check(q_exp.size() == 0, {name, " drained"}, 32'(q_exp.size()), 32'h0);
    active = 1'b0;
  endtask

  initial begin
    // R6 R9 R4: subtract without borrow
    load_begin();
    ram[0] = wd(LIT, LIT, SUB); ram[1] = 16'd7; ram[2] = 16'd3; ram[3] = cw(3);
    expect_wr(16'h0200, 16'd7, "R9 lit push 7");
    expect_wr(16'h0201, 16'd3, "R4 lit push post-inc");
    expect_wr(16'h0200, 16'd4, "R6 7-3");
    run("t_sub");

    // R8 R2 R7: borrow set, skip taken
    load_begin();
    ram[0] = wd(LIT, LIT, SUB); ram[1] = 16'd3; ram[2] = 16'd5;
    ram[3] = cw(10); ram[4] = cw(20); ram[5] = wd(LIT, NOP, NOP);
    ram[6] = 16'h00BB; ram[7] = cw(7);
    ram[10] = wd(SKB, RET, NOP);
    ram[20] = wd(LIT, NOP, NOP); ram[21] = 16'h00CC; ram[22] = cw(22);
    expect_wr(16'h0200, 16'd3, "R9 lit");
    expect_wr(16'h0201, 16'd5, "R9 lit");
    expect_wr(16'h0200, 16'hFFFE, "R6 3-5 wraps");
    expect_wr(16'h0300, 16'd4, "R2 call pushes pc+1");
    expect_wr(16'h0300, 16'd5, "R8 skip bumps return addr");
    expect_wr(16'h0201, 16'h00BB, "R8 caller word skipped");
    run("t_skip_taken");

    // R8: no borrow, skip is ignored
    load_begin();
    ram[0] = wd(LIT, LIT, SUB); ram[1] = 16'd5; ram[2] = 16'd3;
    ram[3] = cw(10); ram[4] = cw(20); ram[5] = wd(LIT, NOP, NOP);
    ram[6] = 16'h00BB; ram[7] = cw(7);
    ram[10] = wd(SKB, RET, NOP);
    ram[20] = wd(LIT, NOP, NOP); ram[21] = 16'h00CC; ram[22] = cw(22);
    expect_wr(16'h0200, 16'd5, "R9 lit");
    expect_wr(16'h0201, 16'd3, "R9 lit");
    expect_wr(16'h0200, 16'd2, "R6 5-3");
    expect_wr(16'h0300, 16'd4, "R2 call");
    expect_wr(16'h0300, 16'd5, "R8 no skip, return to next word");
    expect_wr(16'h0201, 16'h00CC, "R8 not-taken path");
    run("t_skip_not_taken");

    // R6 R9: dup, equal operands give no borrow
    load_begin();
    ram[0] = wd(LIT, DUP, SUB); ram[1] = 16'd4; ram[2] = cw(10); ram[3] = cw(20);
    ram[4] = cw(4); ram[10] = wd(SKB, RET, NOP);
    ram[20] = wd(LIT, NOP, NOP); ram[21] = 16'h00EE; ram[22] = cw(22);
    expect_wr(16'h0200, 16'd4, "R9 lit");
    expect_wr(16'h0200, 16'd4, "R9 dup rewrite");
    expect_wr(16'h0201, 16'd4, "R9 dup copy");
    expect_wr(16'h0200, 16'd0, "R6 4-4");
    expect_wr(16'h0300, 16'd3, "R2 call");
    expect_wr(16'h0300, 16'd4, "R6 equal gives no borrow");
    expect_wr(16'h0201, 16'h00EE, "R6 no-borrow path");
    run("t_dup_equal");

    // R5: push wrap past region end
    load_begin();
    ram[0] = wd(LIT, LIT, LIT); ram[4] = wd(LIT, LIT, LIT); ram[8] = wd(LIT, LIT, LIT);
    ram[1] = 16'd1; ram[2] = 16'd2; ram[3] = 16'd3;
    ram[5] = 16'd4; ram[6] = 16'd5; ram[7] = 16'd6;
    ram[9] = 16'd7; ram[10] = 16'd8; ram[11] = 16'd9; ram[12] = cw(12);
    for (int i = 0; i < 8; i++) expect_wr(16'h0200 + 16'(i), 16'(i + 1), "R5 fill");
    expect_wr(16'h0200, 16'd9, "R5 push wraps to base");
    run("t_wrap_push");

    // R5 R9: pop wrap from empty, drop, to-return, from-return, ignored opcode
    load_begin();
    ram[0] = wd(DROP, LIT, LIT); ram[1] = 16'h0066; ram[2] = 16'h0077;
    ram[3] = wd(TOR, FROMR, 31); ram[4] = cw(4);
    expect_wr(16'h0207, 16'h0066, "R5 pop wraps to top of region");
    expect_wr(16'h0200, 16'h0077, "R5 push wraps forward");
    expect_wr(16'h0300, 16'h0077, "R9 to-return");
    expect_wr(16'h0200, 16'h0077, "R9 from-return");
    run("t_wrap_pop");

    // R2 R3 R7: nested calls, return discards later slots
    load_begin();
    ram[0] = cw(10); ram[1] = wd(LIT, NOP, NOP); ram[2] = 16'h00D1; ram[3] = cw(3);
    ram[10] = cw(20); ram[11] = wd(LIT, RET, LIT); ram[12] = 16'h00D2;
    ram[20] = wd(LIT, RET, LIT); ram[21] = 16'h00D3;
    expect_wr(16'h0300, 16'd1, "R2 outer call");
    expect_wr(16'h0301, 16'd11, "R2 inner call");
    expect_wr(16'h0200, 16'h00D3, "R3 first slot");
    expect_wr(16'h0201, 16'h00D2, "R7 inner return, slot dropped");
    expect_wr(16'h0202, 16'h00D1, "R7 outer return");
    run("t_nested");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule